// File: doc/BRIEF.md
# Page-Mode Read Burst Controller

This block decides, for each access offered to the external asynchronous memory sequencer, whether a read can continue an open page-mode burst on chip-select area 0. A page-mode burst lets the memory return later words of the same page after a short access time. The first read of a burst is timed with the area's full wait-state count. Each later read that is sequential and stays inside the programmed page uses a shorter page wait-state count. Between these reads chip-select and the read strobe stay low and only the address lines move.

The sequencer presents each access for one cycle on the request port. On the following cycle the block returns a decision: whether this access continues the burst and which wait-state count to use. It also keeps a level that tells the sequencer whether to hold chip-select 0 and the read strobe asserted after the access. The page size is set by a 3-bit code. Writes, accesses to other areas, non-sequential addresses, reads that cross a page boundary and the release of chip-select 0 by the sequencer all close the burst.

Top module: `apm_burst_ctrl`

## Requirements
- R1: For every cycle with `req_valid` high, `dec_valid` is high on the next cycle and on no other cycle. `dec_page`, `dec_ws` and `burst_open` change only in that next cycle.
- R2: A read to area 0 that finds no open burst is a first read. It gives `dec_page`=0 and `dec_ws`=`cfg_ws_first`, and `burst_open` goes to 1.
- R3: A read to area 0 continues the burst when a burst is open and its address equals the previous access address plus `ACC_BYTES` (default 2). It then gives `dec_page`=1 and `dec_ws` equal to `cfg_ws_page` zero-extended to 6 bits.
- R4: For `cfg_page_code` values 1 to 6 the page is 2^(code+1) bytes: 4, 8, 16, 32, 64 or 128. A sequential read whose address lies in a different page from the previous access is a first read (R2 timing).
- R5: Codes 0 and 7 disable page mode. Every read is a first read, and `burst_open` stays 0.
- R6: A write (`req_write`=1) gives `dec_page`=0 and `dec_ws`=`cfg_ws_first`, and `burst_open` goes to 0. The read after it is a first read.
- R7: An access whose `req_area` is not 0 gives `dec_page`=0 and `dec_ws`=`cfg_ws_first`, and `burst_open` goes to 0.
- R8: A non-sequential read to area 0 while a burst is open is a first read that opens a new burst. The read at the new address plus `ACC_BYTES` then continues that burst.
- R9: A `cs0_release` pulse with no request closes the burst: `burst_open` is 0 on the next cycle and the next read is a first read. If a request arrives in the same cycle, the request is judged as though the burst were already closed.
- R10: After reset, `burst_open`, `dec_valid` and `dec_page` are 0 and `dec_ws` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_code | input | 3 | Page boundary code (0 and 7 disable) |
| cfg_ws_first | input | 6 | Wait states of area 0 for a first read |
| cfg_ws_page | input | 4 | Wait states for a page read |
| req_valid | input | 1 | Access offered this cycle |
| req_write | input | 1 | Access is a write |
| req_area | input | 2 | Chip-select area of the access |
| req_addr | input | AW (27) | Byte address of the access |
| cs0_release | input | 1 | Sequencer has deasserted chip-select 0 |
| dec_valid | output | 1 | Decision for the previous cycle's request |
| dec_page | output | 1 | Access continues the page burst |
| dec_ws | output | 6 | Wait-state count selected for the access |
| burst_open | output | 1 | Keep chip-select 0 and read strobe asserted |

## Verification
Every decision is registered once, so `dec_valid`, `dec_page`, `dec_ws` and `burst_open` are due exactly one clock after the cycle in which the request is offered. A `cs0_release` pulse shows on `burst_open` after the same single edge. The bench drives each request on a falling edge and holds it for one full cycle. It then reads the outputs at the following falling edge, which lies halfway between the registering edge and the next one. Each scenario also checks the cycle after the decision, to confirm that `dec_valid` has dropped and the decision has not moved.

// File: rtl/apm_pkg.sv
package apm_pkg;
   localparam int unsigned CODE_W   = 3;
   localparam int unsigned AREA_W   = 2;
   localparam int unsigned MIN_CODE = 1;
   localparam int unsigned MAX_CODE = 6;

   function automatic logic code_enabled(input logic [CODE_W-1:0] code);
      return (code >= CODE_W'(MIN_CODE)) && (code <= CODE_W'(MAX_CODE));
   endfunction
endpackage

// File: rtl/apm_page_decode.sv
module apm_page_decode
   import apm_pkg::*;
#(
   parameter int unsigned AW = 27
) (
   input  logic [CODE_W-1:0] code,
   output logic              en,
   output logic [AW-1:0]     low_mask
);
   logic [3:0] sh;

   assign en = code_enabled(code);
   assign sh = {1'b0, code} + 4'd1;

   for (genvar gi = 0; gi < AW; gi++) begin : g_mask
      assign low_mask[gi] = en && (gi < 32'(sh));
   end
endmodule

// File: rtl/apm_seq_match.sv
module apm_seq_match #(
   parameter int unsigned AW        = 27,
   parameter int unsigned ACC_BYTES = 2
) (
   input  logic [AW-1:0] prev_addr,
   input  logic [AW-1:0] cur_addr,
   input  logic [AW-1:0] low_mask,
   output logic          hit
);
   logic [AW-1:0] next_addr;
   logic          seq;
   logic          same_page;

   assign next_addr = prev_addr + AW'(ACC_BYTES);
   assign seq       = (cur_addr == next_addr);
   assign same_page = (((cur_addr ^ prev_addr) & ~low_mask) == '0);
   assign hit       = seq && same_page;
endmodule

// File: rtl/apm_burst_ctrl.sv
module apm_burst_ctrl
   import apm_pkg::*;
#(
   parameter int unsigned AW        = 27,
   parameter int unsigned ACC_BYTES = 2,
   parameter int unsigned WS_W      = 6,
   parameter int unsigned PWS_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_page_code,
   input  logic [WS_W-1:0]   cfg_ws_first,
   input  logic [PWS_W-1:0]  cfg_ws_page,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_area,
   input  logic [AW-1:0]     req_addr,
   input  logic              cs0_release,
   output logic              dec_valid,
   output logic              dec_page,
   output logic [WS_W-1:0]   dec_ws,
   output logic              burst_open
);
   localparam int unsigned PAGE_MAX_LOG2 = MAX_CODE + 1;

   if (PWS_W > WS_W) begin : g_bad_ws
      $error("page wait-state width exceeds first wait-state width");
   end
   if ((ACC_BYTES == 0) || ((ACC_BYTES & (ACC_BYTES - 1)) != 0)) begin : g_bad_acc
      $error("ACC_BYTES must be a power of two");
   end
   if (AW <= PAGE_MAX_LOG2) begin : g_bad_aw
      $error("address too narrow for largest page");
   end

   logic          en;
   logic [AW-1:0] low_mask;
   logic [AW-1:0] last_addr;
   logic          hit;
   logic          eligible;
   logic          cont;

   apm_page_decode #(.AW(AW)) i_dec (
      .code     (cfg_page_code),
      .en       (en),
      .low_mask (low_mask)
   );

   apm_seq_match #(.AW(AW), .ACC_BYTES(ACC_BYTES)) i_match (
      .prev_addr (last_addr),
      .cur_addr  (req_addr),
      .low_mask  (low_mask),
      .hit       (hit)
   );

   assign eligible = en && !req_write && (req_area == '0);
   assign cont     = burst_open && !cs0_release && eligible && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_page   <= 1'b0;
         dec_ws     <= '0;
         burst_open <= 1'b0;
         last_addr  <= '0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_page   <= cont;
            dec_ws     <= cont ? WS_W'(cfg_ws_page) : cfg_ws_first;
            burst_open <= eligible;
            last_addr  <= req_addr;
         end else if (cs0_release) begin
            burst_open <= 1'b0;
         end
      end
   end

   // R1: a decision follows every request by one cycle
   a_r1_dec_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   // R1: decision outputs hold when no request was taken
   a_r1_hold_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(dec_page) && $stable(dec_ws) && !dec_valid));
   // R3: a page read only follows an open burst
   a_r3_page_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !burst_open) |=> !dec_page);
   // R3: page wait-state count fits its narrow field
   a_r3_page_ws_width: assert property (@(posedge clk) disable iff (!rst_n)
      dec_page |-> (dec_ws < WS_W'(1 << PWS_W)));
   // R6 R7: writes and other areas never continue or leave a burst open
   a_r6_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_write || req_area != 2'd0)) |=> (!dec_page && !burst_open));
   // R9: release with no request closes the burst
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cs0_release && !req_valid) |=> !burst_open);
endmodule

// File: tb/test_apm_burst_ctrl.sv
module test_apm_burst_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_page_code = 3'd0;
   logic [5:0]  cfg_ws_first = 6'd37;
   logic [3:0]  cfg_ws_page = 4'd5;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_area = 2'd0;
   logic [26:0] req_addr = '0;
   logic        cs0_release = 1'b0;
   logic        dec_valid, dec_page, burst_open;
   logic [5:0]  dec_ws;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   apm_burst_ctrl i_apm_burst_ctrl (
      .clk, .rst_n, .cfg_page_code, .cfg_ws_first, .cfg_ws_page,
      .req_valid, .req_write, .req_area, .req_addr, .cs0_release,
      .dec_valid, .dec_page, .dec_ws, .burst_open
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // offer one access, then check the decision one cycle later
   task automatic access(input string req, input bit wr, input int area, input int addr,
                         input bit rel, input bit exp_page, input bit exp_open);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_area = 2'(area); req_addr = 27'(addr);
      cs0_release = rel;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cs0_release = 1'b0;
      chk({req, " valid"}, int'(dec_valid), 1);
      chk({req, " page"}, int'(dec_page), int'(exp_page));
      chk({req, " ws"}, int'(dec_ws), exp_page ? int'(cfg_ws_page) : int'(cfg_ws_first));
      chk({req, " open"}, int'(burst_open), int'(exp_open));
   endtask

   task automatic t_reset();
      chk("R10 valid", int'(dec_valid), 0);
      chk("R10 page", int'(dec_page), 0);
      chk("R10 ws", int'(dec_ws), 0);
      chk("R10 open", int'(burst_open), 0);
   endtask

   task automatic t_basic_burst();
      cfg_page_code = 3'd3; // 16-byte pages
      access("R2 first", 0, 0, 'h200, 0, 0, 1);
      access("R3 seq1", 0, 0, 'h202, 0, 1, 1);
      @(negedge clk);
      chk("R1 valid drops", int'(dec_valid), 0);
      chk("R1 page stable", int'(dec_page), 1);
      access("R3 seq2", 0, 0, 'h204, 0, 1, 1);
      for (int a = 'h206; a <= 'h20E; a += 2) access("R3 seq", 0, 0, a, 0, 1, 1);
      access("R4 cross16", 0, 0, 'h210, 0, 0, 1);
      access("R4 after cross", 0, 0, 'h212, 0, 1, 1);
   endtask

   task automatic t_small_page();
      cfg_page_code = 3'd1; // 4-byte pages
      access("R4 p4 first", 0, 0, 'h100, 0, 0, 1);
      access("R4 p4 seq", 0, 0, 'h102, 0, 1, 1);
      access("R4 p4 cross", 0, 0, 'h104, 0, 0, 1);
      cfg_page_code = 3'd6; // 128-byte pages
      access("R4 p128 first", 0, 0, 'h17C, 0, 0, 1);
      access("R4 p128 cross", 0, 0, 'h17E, 0, 1, 1);
      access("R4 p128 edge", 0, 0, 'h180, 0, 0, 1);
   endtask

   task automatic t_disabled();
      cfg_page_code = 3'd0;
      access("R5 off a", 0, 0, 'h300, 0, 0, 0);
      access("R5 off b", 0, 0, 'h302, 0, 0, 0);
      cfg_page_code = 3'd7;
      access("R5 rsv a", 0, 0, 'h304, 0, 0, 0);
      access("R5 rsv b", 0, 0, 'h306, 0, 0, 0);
   endtask

   task automatic t_breakers();
      cfg_page_code = 3'd5; // 64-byte pages
      cfg_ws_first = 6'd12; cfg_ws_page = 4'd15;
      access("R6 open", 0, 0, 'h400, 0, 0, 1);
      access("R6 write", 1, 0, 'h402, 0, 0, 0);
      access("R6 after write", 0, 0, 'h404, 0, 0, 1);
      access("R7 area1", 0, 1, 'h406, 0, 0, 0);
      access("R7 after area", 0, 0, 'h408, 0, 0, 1);
      access("R8 jump", 0, 0, 'h420, 0, 0, 1);
      access("R8 seq new", 0, 0, 'h422, 0, 1, 1);
      access("R8 backward", 0, 0, 'h420, 0, 0, 1);
   endtask

   task automatic t_release();
      cfg_page_code = 3'd4;
      access("R9 open", 0, 0, 'h500, 0, 0, 1);
      @(negedge clk);
      cs0_release = 1'b1;
      @(negedge clk);
      cs0_release = 1'b0;
      chk("R9 closed", int'(burst_open), 0);
      chk("R9 no decision", int'(dec_valid), 0);
      access("R9 after release", 0, 0, 'h502, 0, 0, 1);
      access("R9 same-cycle", 0, 0, 'h504, 1, 0, 1);
      access("R9 resumes", 0, 0, 'h506, 0, 1, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_burst();
      t_small_page();
      t_disabled();
      t_breakers();
      t_release();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule